// File: doc/BRIEF.md
# Sample and Hold Timing Controller

This block produces the timing that a successive-approximation converter needs around each measurement. It picks one of four trigger sources. Source 0 is a one-cycle software start pulse and sources 1 to 3 are external timer outputs. The chosen trigger can be inverted, and it is brought into the converter clock domain through a two-flop synchroniser. A rising edge of the synchronised trigger opens a sample window on `sample_en`. A fixed 13-cycle conversion window on `conv_active` follows the sample window. The end of the conversion window is marked by a one-cycle `conv_done` pulse, which comes with the result word sampled from `result_in`.

The sample window can be set in one of two ways. In direct mode the window lasts as long as the trigger stays at its active level. In timer mode a down-counter holds the window open for a number of converter clocks taken from a non-linear 4-bit code table. The slot index picks which of two code fields applies: one field serves the lower half of the slot range and the other serves the upper half. A trigger edge that arrives while a sample or a conversion is still running is dropped and reported on `timing_ovf`.

Top module: `sh_timing_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is released, `sample_en`, `conv_active`, `conv_done`, `busy`, `timing_ovf` and `result_out` are all 0. A reset in the middle of an operation clears them at the next clock edge.
- R2: `src_sel` picks the trigger: 0 selects `sw_start`, 1 selects `ext_trig[0]`, 2 selects `ext_trig[1]` and 3 selects `ext_trig[2]`. Activity on a source that is not selected starts nothing.
- R3: When `invert` is 1, the selected trigger is complemented, so a falling edge on the input line starts an operation and a low level on the line holds a direct-mode window open.
- R4: When the selected trigger first shows its active level just before a rising clock edge E0, `sample_en` goes high on edge E0+2.
- R5: In direct mode (`pulse_mode`=0), `sample_en` stays high for exactly as many clock cycles as the trigger was held at its active level.
- R6: In timer mode (`pulse_mode`=1), `sample_en` stays high for N cycles, where the code maps as follows: 0→4, 1→8, 2→16, 3→32, 4→64, 5→96, 6→128, 7→192, 8→256, 9→384, 10→512, 11→768, and 12 to 15→1024.
- R7: In timer mode the code comes from `sht_lo` when `slot_idx` is below 8 and from `sht_hi` when `slot_idx` is 8 to 15.
- R8: `conv_active` rises on the edge where `sample_en` falls and stays high for exactly 13 cycles. It is never high together with `sample_en`.
- R9: `conv_done` is high for one cycle, starting on the edge where `conv_active` falls. On that edge `result_out` loads `result_in`, and it then holds that value until the next completion.
- R10: A trigger rising edge that the controller sees while a sample or a conversion is in progress gives a one-cycle `timing_ovf` pulse. Such an edge starts no new sample and leaves the current operation unchanged. This includes an edge seen on the last conversion cycle, where `timing_ovf` and `conv_done` are high together.
- R11: `busy` is 1 exactly in the cycles where `sample_en` or `conv_active` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_start | input | 1 | Software start pulse (source 0) |
| ext_trig | input | 3 | External timer trigger lines (sources 1 to 3) |
| src_sel | input | 2 | Trigger source select |
| invert | input | 1 | Trigger polarity inversion |
| pulse_mode | input | 1 | 0 = direct window, 1 = timer window |
| sht_lo | input | 4 | Sample-time code for slots 0 to 7 |
| sht_hi | input | 4 | Sample-time code for slots 8 to 15 |
| slot_idx | input | 4 | Index of the slot being converted |
| result_in | input | 12 | Converter result word |
| sample_en | output | 1 | Sample window level |
| conv_active | output | 1 | Conversion window level |
| conv_done | output | 1 | One-cycle completion pulse |
| result_out | output | 12 | Result captured at completion |
| busy | output | 1 | Sample or conversion in progress |
| timing_ovf | output | 1 | One-cycle pulse for a request that was too early |

## Verification
The completion of one conversion and the arrival of a premature request can land on the same clock edge, and that is the case to watch. The bench starts a 4-cycle timer-mode sample and then issues a second software start timed so that its synchronised edge is evaluated on the final conversion cycle. It then requires `conv_done` and `timing_ovf` to be high in the same sampled cycle, with only one sample window and one completion. The same request placed one cycle later must instead start a fresh sample without any overflow, which shows exactly where the overflow boundary lies.

// File: rtl/shtc_pkg.sv
package shtc_pkg;

  localparam int SHT_CNT_W = 11;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } shtc_state_t;

  // Non-linear sample-time code table
  function automatic logic [SHT_CNT_W-1:0] sht_code_to_cycles(input logic [3:0] code);
    logic [SHT_CNT_W-1:0] n;
    case (code)
      4'd0:    n = 11'd4;
      4'd1:    n = 11'd8;
      4'd2:    n = 11'd16;
      4'd3:    n = 11'd32;
      4'd4:    n = 11'd64;
      4'd5:    n = 11'd96;
      4'd6:    n = 11'd128;
      4'd7:    n = 11'd192;
      4'd8:    n = 11'd256;
      4'd9:    n = 11'd384;
      4'd10:   n = 11'd512;
      4'd11:   n = 11'd768;
      default: n = 11'd1024;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/shtc_trig_front.sv
module shtc_trig_front #(
  parameter int NUM_EXT     = 3,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_EXT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_start,
  input  logic [NUM_EXT-1:0] ext_trig,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               invert,
  output logic               trig_lvl,
  output logic               trig_rise
);

  logic [(1<<SEL_W)-1:0]  cand;
  logic                   raw;
  logic [SYNC_STAGES-1:0] chain;
  logic                   prev_q;

  always_comb begin
    cand            = '0;
    cand[0]         = sw_start;
    cand[NUM_EXT:1] = ext_trig;
  end

  assign raw = cand[src_sel] ^ invert;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      prev_q <= 1'b0;
    end else begin
      chain  <= {chain[SYNC_STAGES-2:0], raw};
      prev_q <= chain[SYNC_STAGES-1];
    end
  end

  assign trig_lvl  = chain[SYNC_STAGES-1];
  assign trig_rise = chain[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/shtc_down_timer.sv
module shtc_down_timer #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expire
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val - W'(1);
    end else if (run && (cnt != '0)) begin
      cnt <= cnt - W'(1);
    end
  end

  assign expire = (cnt == '0);

endmodule

// File: rtl/sh_timing_ctrl.sv
module sh_timing_ctrl #(
  parameter int NUM_EXT     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_SLOTS   = 16,
  parameter int RES_W       = 12,
  parameter int CONV_CYCLES = 13,
  parameter int CNT_W       = shtc_pkg::SHT_CNT_W,
  localparam int SEL_W      = $clog2(NUM_EXT + 1),
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int CV_W       = $clog2(CONV_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_start,
  input  logic [NUM_EXT-1:0] ext_trig,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               invert,
  input  logic               pulse_mode,
  input  logic [3:0]         sht_lo,
  input  logic [3:0]         sht_hi,
  input  logic [SLOT_W-1:0]  slot_idx,
  input  logic [RES_W-1:0]   result_in,
  output logic               sample_en,
  output logic               conv_active,
  output logic               conv_done,
  output logic [RES_W-1:0]   result_out,
  output logic               busy,
  output logic               timing_ovf
);

  import shtc_pkg::*;

  shtc_state_t state;
  logic        trig_lvl, trig_rise;
  logic        mode_q;
  logic        st_load, st_run, st_expire;
  logic        cv_load, cv_run, cv_expire;
  logic        upper_half;
  logic [3:0]  sel_code;
  logic [CNT_W-1:0] st_val;
  logic        exit_sample;

  shtc_trig_front #(
    .NUM_EXT     (NUM_EXT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_front (
    .clk       (clk),
    .rst       (rst),
    .sw_start  (sw_start),
    .ext_trig  (ext_trig),
    .src_sel   (src_sel),
    .invert    (invert),
    .trig_lvl  (trig_lvl),
    .trig_rise (trig_rise)
  );

  // Upper half of slot range uses the second code field
  assign upper_half = (slot_idx >= SLOT_W'(NUM_SLOTS / 2));
  assign sel_code   = upper_half ? sht_hi : sht_lo;
  assign st_val     = CNT_W'(sht_code_to_cycles(sel_code));

  assign st_load = (state == ST_IDLE) && trig_rise && pulse_mode;
  assign st_run  = (state == ST_SAMPLE) && mode_q && !st_expire;

  shtc_down_timer #(.W(CNT_W)) u_sample_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (st_load),
    .load_val (st_val),
    .run      (st_run),
    .expire   (st_expire)
  );

  assign exit_sample = (state == ST_SAMPLE) && (mode_q ? st_expire : !trig_lvl);
  assign cv_load     = exit_sample;
  assign cv_run      = (state == ST_CONV) && !cv_expire;

  shtc_down_timer #(.W(CV_W)) u_conv_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (cv_load),
    .load_val (CV_W'(CONV_CYCLES)),
    .run      (cv_run),
    .expire   (cv_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      mode_q      <= 1'b0;
      sample_en   <= 1'b0;
      conv_active <= 1'b0;
      conv_done   <= 1'b0;
      busy        <= 1'b0;
      timing_ovf  <= 1'b0;
      result_out  <= '0;
    end else begin
      conv_done  <= 1'b0;
      timing_ovf <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (trig_rise) begin
            state     <= ST_SAMPLE;
            mode_q    <= pulse_mode;
            sample_en <= 1'b1;
            busy      <= 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (trig_rise) timing_ovf <= 1'b1;
          if (exit_sample) begin
            state       <= ST_CONV;
            sample_en   <= 1'b0;
            conv_active <= 1'b1;
          end
        end
        ST_CONV: begin
          if (trig_rise) timing_ovf <= 1'b1;
          if (cv_expire) begin
            state       <= ST_IDLE;
            conv_active <= 1'b0;
            busy        <= 1'b0;
            conv_done   <= 1'b1;
            result_out  <= result_in;
          end
        end
        default: begin
          state       <= ST_IDLE;
          sample_en   <= 1'b0;
          conv_active <= 1'b0;
          busy        <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/shtc_checker.sv
module shtc_checker (
  input logic clk,
  input logic rst,
  input logic sample_en,
  input logic conv_active,
  input logic conv_done,
  input logic busy,
  input logic timing_ovf
);

  // R8
  sample_conv_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sample_en && conv_active));

  // R8
  conv_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_active) |-> $fell(sample_en));

  // R9
  done_at_conv_end_chk: assert property (@(posedge clk) disable iff (rst)
    conv_done |-> ($past(conv_active) && !conv_active));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> !conv_done);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    timing_ovf |-> $past(busy));

  // R11
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    busy == (sample_en || conv_active));

endmodule

bind sh_timing_ctrl shtc_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .sample_en   (sample_en),
  .conv_active (conv_active),
  .conv_done   (conv_done),
  .busy        (busy),
  .timing_ovf  (timing_ovf)
);

// File: tb/tb_sh_timing_ctrl.sv
`timescale 1ns/1ps
module tb_sh_timing_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_start = 1'b0;
  logic [2:0]  ext_trig = 3'b000;
  logic [1:0]  src_sel = 2'd0;
  logic        invert = 1'b0;
  logic        pulse_mode = 1'b0;
  logic [3:0]  sht_lo = 4'd0;
  logic [3:0]  sht_hi = 4'd0;
  logic [3:0]  slot_idx = 4'd0;
  logic [11:0] result_in = 12'd0;
  logic        sample_en, conv_active, conv_done, busy, timing_ovf;
  logic [11:0] result_out;

  always #2 clk = ~clk;

  sh_timing_ctrl dut (
    .clk(clk), .rst(rst), .sw_start(sw_start), .ext_trig(ext_trig),
    .src_sel(src_sel), .invert(invert), .pulse_mode(pulse_mode),
    .sht_lo(sht_lo), .sht_hi(sht_hi), .slot_idx(slot_idx),
    .result_in(result_in), .sample_en(sample_en), .conv_active(conv_active),
    .conv_done(conv_done), .result_out(result_out), .busy(busy),
    .timing_ovf(timing_ovf)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int n_samp, n_conv, n_done, n_ovf, n_busy, n_both;
  logic [11:0] last_result;

  // {pulse, src[1:0], code[3:0], slot[3:0], expected sample cycles[10:0]}
  localparam int NV = 17;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 2'd0, 4'd0,  4'd3,  11'd4},
    {1'b1, 2'd1, 4'd1,  4'd8,  11'd8},
    {1'b1, 2'd2, 4'd2,  4'd7,  11'd16},
    {1'b1, 2'd3, 4'd3,  4'd15, 11'd32},
    {1'b1, 2'd0, 4'd4,  4'd0,  11'd64},
    {1'b1, 2'd1, 4'd5,  4'd9,  11'd96},
    {1'b1, 2'd2, 4'd6,  4'd12, 11'd128},
    {1'b1, 2'd3, 4'd7,  4'd5,  11'd192},
    {1'b1, 2'd0, 4'd8,  4'd10, 11'd256},
    {1'b1, 2'd1, 4'd9,  4'd2,  11'd384},
    {1'b1, 2'd2, 4'd10, 4'd11, 11'd512},
    {1'b1, 2'd3, 4'd11, 4'd6,  11'd768},
    {1'b1, 2'd0, 4'd12, 4'd13, 11'd1024},
    {1'b1, 2'd1, 4'd15, 4'd1,  11'd1024},
    {1'b0, 2'd2, 4'd0,  4'd4,  11'd7},
    {1'b0, 2'd1, 4'd0,  4'd9,  11'd20},
    {1'b0, 2'd0, 4'd0,  4'd4,  11'd1}
  };

  always @(negedge clk) begin
    if (sample_en)   n_samp++;
    if (conv_active) n_conv++;
    if (busy)        n_busy++;
    if (timing_ovf)  n_ovf++;
    if (conv_done) begin
      n_done++;
      last_result = result_out;
    end
    if (conv_done && timing_ovf) n_both++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    @(posedge clk); #1;
    n_samp = 0; n_conv = 0; n_done = 0; n_ovf = 0; n_busy = 0; n_both = 0;
  endtask

  // Drive the selected source active for hold cycles (line level honours invert)
  task automatic fire(input logic [1:0] src, input int hold);
    @(negedge clk);
    if (src == 2'd0) begin
      sw_start = 1'b1;
      @(negedge clk);
      sw_start = 1'b0;
    end else begin
      ext_trig[src-1] = ~invert;
      repeat (hold) @(negedge clk);
      ext_trig[src-1] = invert;
    end
  endtask

  task automatic wait_done();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (n_done > 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [21:0] v;
    logic [3:0]  code, other;
    int          exp, lat;
    logic [11:0] rv;

    // R1 reset state
    repeat (4) @(negedge clk);
    check("R1 reset outputs", {sample_en, conv_active, conv_done, busy, timing_ovf}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {sample_en, conv_active, conv_done, busy, timing_ovf}, 0);
    check("R1 result reset", result_out, 0);

    // R2 R5 R6 R7 R8 R9 R11 vector walk
    for (int i = 0; i < NV; i++) begin
      v    = VEC[i];
      code = v[18:15];
      exp  = int'(v[10:0]);
      other = (code == 4'd2) ? 4'd3 : 4'd2;
      rv   = 12'h5A0 ^ 12'(i * 37);
      @(negedge clk);
      pulse_mode = v[21];
      src_sel    = v[20:19];
      slot_idx   = v[14:11];
      sht_lo     = (v[14:11] < 4'd8) ? code : other;
      sht_hi     = (v[14:11] < 4'd8) ? other : code;
      result_in  = rv;
      repeat (3) @(negedge clk);
      clear_counts();
      fire(v[20:19], v[21] ? 2 : exp);
      wait_done();
      check($sformatf("R6 R7 R5 sample length vec %0d", i), n_samp, exp);
      check($sformatf("R8 conv length vec %0d", i), n_conv, 13);
      check($sformatf("R9 done count vec %0d", i), n_done, 1);
      check($sformatf("R9 result vec %0d", i), last_result, rv);
      check($sformatf("R10 no ovf vec %0d", i), n_ovf, 0);
      check($sformatf("R11 busy length vec %0d", i), n_busy, exp + 13);
    end

    // R9 result held after completion
    rv = result_out;
    @(negedge clk);
    result_in = ~rv;
    repeat (4) @(negedge clk);
    check("R9 result held", result_out, rv);

    // R4 latency: active level before E0, sample_en after E0+2
    @(negedge clk);
    pulse_mode = 1'b1; src_sel = 2'd0; slot_idx = 4'd0; sht_lo = 4'd0;
    repeat (3) @(negedge clk);
    clear_counts();
    @(negedge clk);
    sw_start = 1'b1;
    lat = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      sw_start = 1'b0;
      lat++;
      if (sample_en) break;
    end
    check("R4 start latency", lat, 3);
    wait_done();

    // R2 unselected sources ignored
    @(negedge clk);
    src_sel = 2'd2; pulse_mode = 1'b0;
    repeat (3) @(negedge clk);
    clear_counts();
    @(negedge clk);
    ext_trig[0] = 1'b1; ext_trig[2] = 1'b1; sw_start = 1'b1;
    repeat (3) @(negedge clk);
    ext_trig[0] = 1'b0; ext_trig[2] = 1'b0; sw_start = 1'b0;
    repeat (10) @(negedge clk);
    check("R2 unselected no sample", n_samp, 0);
    check("R2 unselected not busy", n_busy, 0);

    // R3 inverted polarity, direct mode, low level holds window
    @(negedge clk);
    ext_trig[1] = 1'b1; invert = 1'b1;
    repeat (4) @(negedge clk);
    clear_counts();
    fire(2'd2, 6);
    wait_done();
    check("R3 inverted sample length", n_samp, 6);
    check("R3 inverted done", n_done, 1);
    @(negedge clk);
    ext_trig[1] = 1'b0; invert = 1'b0;
    repeat (4) @(negedge clk);

    // R10 request during conversion
    @(negedge clk);
    pulse_mode = 1'b1; src_sel = 2'd0; slot_idx = 4'd2; sht_lo = 4'd0;
    repeat (3) @(negedge clk);
    clear_counts();
    fire(2'd0, 1);
    repeat (7) @(negedge clk);
    fire(2'd0, 1);
    wait_done();
    check("R10 ovf during conversion", n_ovf, 1);
    check("R10 single sample", n_samp, 4);
    check("R10 conv unchanged", n_conv, 13);
    check("R10 single done", n_done, 1);

    // R10 request seen on last conversion cycle: done and ovf together
    clear_counts();
    fire(2'd0, 1);
    repeat (15) @(negedge clk);
    fire(2'd0, 1);
    wait_done();
    check("R10 done with ovf same cycle", n_both, 1);
    check("R10 boundary ovf", n_ovf, 1);
    check("R10 boundary no second sample", n_samp, 4);

    // R10 one cycle later: new operation starts, no overflow
    clear_counts();
    fire(2'd0, 1);
    repeat (16) @(negedge clk);
    fire(2'd0, 1);
    repeat (60) @(negedge clk);
    check("R10 late request ovf", n_ovf, 0);
    check("R10 late request samples", n_samp, 8);
    check("R10 late request dones", n_done, 2);

    // R1 reset in the middle of a sample window
    @(negedge clk);
    sht_lo = 4'd5;
    fire(2'd0, 1);
    repeat (6) @(negedge clk);
    check("R1 mid-op busy before reset", busy, 1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-op reset clears", {sample_en, conv_active, conv_done, busy, timing_ovf}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", busy, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule